// File: doc/BRIEF.md
# Signed Non-Restoring Word Divider

This block divides a signed dividend by a signed 36-bit divisor over several clock cycles and returns a truncated quotient and a remainder, both 36-bit two's complement words. The dividend is either one 36-bit word, sign-extended internally, or a 72-bit two's complement value formed from a high and a low word. Each cycle performs one shift-and-add-or-subtract step. The divisor's own sign, together with the sign of the partial remainder, decides whether that step adds or subtracts. The divisor's magnitude is never formed.

A caller raises `start_i` for one cycle with the operands valid. The block copies them and produces one quotient bit per cycle. It then restores a negative final remainder and fixes the result signs. For one cycle it pulses `done_o`. A quotient that cannot fit in a signed word sets `ovf_o` (no-divide) and leaves the previous quotient and remainder in place. The first step detects this case, so the block finishes early. A quotient of exactly -2^35 is still accepted. A single-word dividend whose magnitude is below 2^18 takes a shortened path of 18 quotient steps.

The controller has five states. `S_IDLE` waits for start and moves to `S_FIRST`. `S_FIRST` performs the unshifted first step. From there it goes to `S_CHK` when a long-path first step yields a quotient 1, and to `S_STEP` otherwise. `S_STEP` performs shifted steps until its counter expires and then moves to `S_FIX`. `S_CHK` (overflow or minimum-quotient decision) and `S_FIX` (restore and sign fix) each raise done and return to `S_IDLE`.

Top module: `nr_signed_div`

## Requirements
- R1: After reset, done_o, ovf_o, quot_o and rem_o are all zero.
- R2: In single mode (dbl_i=0), the dividend is dend_lo_i and dend_hi_i has no effect. The quotient is truncated toward zero, the remainder carries the dividend's sign and its magnitude is below the divisor's, for every sign combination.
- R3: In double mode (dbl_i=1), the dividend is the 72-bit two's complement value {dend_hi_i, dend_lo_i}, with the same quotient and remainder rules as R2.
- R4: done_o rises 37 clock edges after the edge that samples start_i on the long path. On the short path (single mode, nonzero divisor, dividend magnitude below 2^18) it rises after 19 edges.
- R5: The single-mode dividend -2^35 (36'h800000000) is divided correctly on the long path, with latency 37.
- R6: When the true quotient magnitude is 2^35 or more and the quotient is not exactly -2^35, ovf_o=1, quot_o and rem_o keep their previous values, and done_o rises 2 edges after the start edge.
- R7: A zero divisor always gives ovf_o=1 with the timing of R6.
- R8: A true quotient of exactly -2^35 gives ovf_o=0, quot_o=36'h800000000 and the correctly signed remainder, with done_o 2 edges after start.
- R9: done_o is high for exactly one cycle. quot_o, rem_o and ovf_o change only in the cycle done_o rises.
- R10: start_i is ignored while a division is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a division |
| dbl_i | input | 1 | 1: 72-bit dividend, 0: single-word dividend |
| dend_hi_i | input | 36 | Dividend high word (double mode only) |
| dend_lo_i | input | 36 | Dividend low word, or the whole single-mode dividend |
| dsor_i | input | 36 | Signed divisor |
| quot_o | output | 36 | Signed quotient |
| rem_o | output | 36 | Signed remainder |
| ovf_o | output | 1 | No-divide: the quotient does not fit |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is the narrow band where the first step signals overflow but the quotient is still legal. This happens only when the dividend equals 2^35 times the divisor magnitude plus less than one divisor, and the operand signs differ. The bench builds such dividends exactly in double mode, and in single mode through -2^35 divided by 1. It pairs each with near misses: a remainder one divisor too large, and the same magnitude with matching signs. The short path is reached by single-mode dividends just under 2^18. The case just above it, and the case of the most negative word, are checked through the completion latency.

// File: rtl/nr_div_pkg.sv
package nr_div_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_FIRST,
        S_STEP,
        S_CHK,
        S_FIX
    } div_state_t;
endpackage

// File: rtl/nr_div_addsub.sv
// One non-restoring step: the operation is chosen from the sign of the
// partial remainder and the raw sign of the divisor (equal signs subtract).
module nr_div_addsub #(
    parameter int WORD = 36,
    parameter int PW   = WORD + 3
) (
    input  logic [PW-1:0]   p_i,
    input  logic [WORD-1:0] d_i,
    output logic [PW-1:0]   p_o
);
    logic [PW-1:0] dx;
    logic          do_sub;

    assign dx     = {{(PW-WORD){d_i[WORD-1]}}, d_i};
    assign do_sub = (p_i[PW-1] == d_i[WORD-1]);
    assign p_o    = do_sub ? (p_i - dx) : (p_i + dx);
endmodule

// File: rtl/nr_div_prep.sv
// Operand preparation: dividend widening, magnitude, sign bookkeeping and
// the choice of the shortened path.
module nr_div_prep #(
    parameter int WORD     = 36,
    parameter int HALF     = 18,
    parameter bit SHORT_EN = 1'b1,
    parameter int DW       = 2 * WORD
) (
    input  logic            dbl_i,
    input  logic [WORD-1:0] hi_i,
    input  logic [WORD-1:0] lo_i,
    input  logic [WORD-1:0] dsor_i,
    output logic [DW-1:0]   mag_o,
    output logic            dneg_o,
    output logic            qneg_o,
    output logic            short_o
);
    logic [DW-1:0] full;

    assign full   = dbl_i ? {hi_i, lo_i} : {{WORD{lo_i[WORD-1]}}, lo_i};
    assign dneg_o = full[DW-1];
    assign mag_o  = dneg_o ? (~full + DW'(1)) : full;
    assign qneg_o = dneg_o ^ dsor_i[WORD-1];

    generate
        if (SHORT_EN) begin : g_short
            assign short_o = !dbl_i && (mag_o[WORD-1:HALF] == '0) && (dsor_i != '0);
        end else begin : g_no_short
            assign short_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/nr_div_fix.sv
// Final correction: remainder restore, sign fix-up and the test that
// admits a quotient of exactly the most negative word.
module nr_div_fix #(
    parameter int WORD = 36,
    parameter int PW   = WORD + 3
) (
    input  logic [PW-1:0]   prem_i,
    input  logic [WORD-2:0] low_i,
    input  logic [WORD-1:0] dsor_i,
    input  logic [WORD-1:0] qbits_i,
    input  logic            dneg_i,
    input  logic            qneg_i,
    output logic [WORD-1:0] quot_o,
    output logic [WORD-1:0] rem_o,
    output logic            min_ok_o,
    output logic [WORD-1:0] rem_min_o
);
    logic [PW-1:0]   restored;
    logic [PW-1:0]   low_ext;
    logic [PW-1:0]   low_cmp;
    logic [WORD-1:0] r_mag;
    logic [WORD-1:0] low_w;

    nr_div_addsub #(.WORD(WORD), .PW(PW)) u_restore (
        .p_i(prem_i), .d_i(dsor_i), .p_o(restored)
    );

    assign low_ext = {{(PW-WORD+1){1'b0}}, low_i};

    nr_div_addsub #(.WORD(WORD), .PW(PW)) u_lowcmp (
        .p_i(low_ext), .d_i(dsor_i), .p_o(low_cmp)
    );

    assign r_mag     = prem_i[PW-1] ? restored[WORD-1:0] : prem_i[WORD-1:0];
    assign rem_o     = dneg_i ? (~r_mag + WORD'(1)) : r_mag;
    assign quot_o    = qneg_i ? (~qbits_i + WORD'(1)) : qbits_i;
    assign low_w     = {1'b0, low_i};
    assign rem_min_o = dneg_i ? (~low_w + WORD'(1)) : low_w;
    assign min_ok_o  = (prem_i == '0) && qneg_i && low_cmp[PW-1];
endmodule

// File: rtl/nr_signed_div.sv
module nr_signed_div
    import nr_div_pkg::*;
#(
    parameter int WORD     = 36,
    parameter int HALF     = 18,
    parameter bit SHORT_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            dbl_i,
    input  logic [WORD-1:0] dend_hi_i,
    input  logic [WORD-1:0] dend_lo_i,
    input  logic [WORD-1:0] dsor_i,
    output logic [WORD-1:0] quot_o,
    output logic [WORD-1:0] rem_o,
    output logic            ovf_o,
    output logic            done_o
);
    localparam int DW = 2 * WORD;
    localparam int PW = WORD + 3;
    localparam int CW = $clog2(WORD + 1);
    localparam logic [CW-1:0]   LONG_CNT  = CW'(WORD - 1);
    localparam logic [CW-1:0]   SHORT_CNT = CW'(HALF - 1);
    localparam logic [WORD-1:0] MIN_Q     = {1'b1, {(WORD-1){1'b0}}};

    div_state_t state_q, state_d;

    logic [DW-1:0]   mag, adj;
    logic            dneg, qneg, short_ok;
    logic [PW-1:0]   prem_q, step_in, step_out;
    logic [WORD-2:0] feed_q, low_q;
    logic [WORD-1:0] qbits_q, dsor_q;
    logic [CW-1:0]   cnt_q;
    logic            dneg_q, qneg_q, short_q, qbit;
    logic [WORD-1:0] quot_fix, rem_fix, rem_min;
    logic            min_ok;

    nr_div_prep #(.WORD(WORD), .HALF(HALF), .SHORT_EN(SHORT_EN), .DW(DW)) u_prep (
        .dbl_i(dbl_i), .hi_i(dend_hi_i), .lo_i(dend_lo_i), .dsor_i(dsor_i),
        .mag_o(mag), .dneg_o(dneg), .qneg_o(qneg), .short_o(short_ok)
    );

    assign adj = short_ok ? (mag << HALF) : mag;

    // first step is unshifted; later steps shift in the next dividend bit
    assign step_in = (state_q == S_FIRST) ? prem_q : {prem_q[PW-2:0], feed_q[WORD-2]};

    nr_div_addsub #(.WORD(WORD), .PW(PW)) u_step (
        .p_i(step_in), .d_i(dsor_q), .p_o(step_out)
    );

    assign qbit = ~step_out[PW-1];

    nr_div_fix #(.WORD(WORD), .PW(PW)) u_fix (
        .prem_i(prem_q), .low_i(low_q), .dsor_i(dsor_q), .qbits_i(qbits_q),
        .dneg_i(dneg_q), .qneg_i(qneg_q), .quot_o(quot_fix), .rem_o(rem_fix),
        .min_ok_o(min_ok), .rem_min_o(rem_min)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = S_FIRST;
            S_FIRST: state_d = (!short_q && qbit) ? S_CHK : S_STEP;
            S_STEP:  if (cnt_q == CW'(1)) state_d = S_FIX;
            S_CHK:   state_d = S_IDLE;
            S_FIX:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // iteration datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prem_q  <= '0;
            feed_q  <= '0;
            low_q   <= '0;
            qbits_q <= '0;
            dsor_q  <= '0;
            cnt_q   <= '0;
            dneg_q  <= 1'b0;
            qneg_q  <= 1'b0;
            short_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    prem_q  <= {2'b00, adj[DW-1:WORD-1]};
                    feed_q  <= adj[WORD-2:0];
                    low_q   <= mag[WORD-2:0];
                    qbits_q <= '0;
                    dsor_q  <= dsor_i;
                    cnt_q   <= short_ok ? SHORT_CNT : LONG_CNT;
                    dneg_q  <= dneg;
                    qneg_q  <= qneg;
                    short_q <= short_ok;
                end
                S_FIRST: begin
                    prem_q  <= step_out;
                    qbits_q <= {qbits_q[WORD-2:0], qbit};
                end
                S_STEP: begin
                    prem_q  <= step_out;
                    qbits_q <= {qbits_q[WORD-2:0], qbit};
                    feed_q  <= {feed_q[WORD-3:0], 1'b0};
                    cnt_q   <= cnt_q - CW'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quot_o <= '0;
            rem_o  <= '0;
            ovf_o  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                S_FIX: begin
                    quot_o <= quot_fix;
                    rem_o  <= rem_fix;
                    ovf_o  <= 1'b0;
                    done_o <= 1'b1;
                end
                S_CHK: begin
                    done_o <= 1'b1;
                    if (min_ok) begin
                        quot_o <= MIN_Q;
                        rem_o  <= rem_min;
                        ovf_o  <= 1'b0;
                    end else begin
                        ovf_o  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_QUOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(quot_o) && $stable(rem_o) && $stable(ovf_o))); // R9
    AST_NODIV_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ovf_o) |-> ($stable(quot_o) && $stable(rem_o))); // R6
    AST_FIX_ENDS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FIX) |=> (done_o && !ovf_o && state_q == S_IDLE)); // R4
    AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STEP) |=> (state_q == S_STEP || state_q == S_FIX)); // R10
    AST_ZERO_DSOR_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FIRST && !short_q && dsor_q == '0) |=> (state_q == S_CHK)); // R7
    AST_CHK_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHK) |=> done_o); // R6
endmodule

// File: tb/tb_nr_signed_div.sv
`timescale 1ns/1ps
module tb_nr_signed_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        dbl_i = 1'b0;
    logic [35:0] dend_hi_i = '0, dend_lo_i = '0, dsor_i = '0;
    logic [35:0] quot_o, rem_o;
    logic        ovf_o, done_o;
    int          n_chk = 0, n_err = 0;
    bit          ended = 1'b0;

    always #2.5 clk = ~clk;

    nr_signed_div dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dbl_i(dbl_i),
        .dend_hi_i(dend_hi_i), .dend_lo_i(dend_lo_i), .dsor_i(dsor_i),
        .quot_o(quot_o), .rem_o(rem_o), .ovf_o(ovf_o), .done_o(done_o)
    );

    task automatic chk(input string what, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", what, act, exp);
        end
    endtask

    // reference model built from the requirements
    task automatic model(input bit dbl, input logic [35:0] hi, input logic [35:0] lo,
                         input logic [35:0] dsor, output logic [35:0] q,
                         output logic [35:0] r, output bit ovf, output int lat);
        logic [71:0] full, mag, dm, qm, rm;
        bit neg, qneg;
        full = dbl ? {hi, lo} : {{36{lo[35]}}, lo};
        neg  = full[71];
        mag  = neg ? (~full + 72'd1) : full;
        dm   = dsor[35] ? {36'd0, ~dsor + 36'd1} : {36'd0, dsor};
        qneg = neg ^ dsor[35];
        q = '0; r = '0; ovf = 1'b1; lat = 2;
        if (dm != 72'd0) begin
            qm = mag / dm;
            rm = mag % dm;
            if (qm < 72'h8_0000_0000) begin
                ovf = 1'b0;
                lat = (!dbl && mag < 72'd262144) ? 19 : 37;
                q = qneg ? (~qm[35:0] + 36'd1) : qm[35:0];
                r = neg ? (~rm[35:0] + 36'd1) : rm[35:0];
            end else if (qm == 72'h8_0000_0000 && qneg) begin
                ovf = 1'b0;
                q = 36'h8_0000_0000;
                r = neg ? (~rm[35:0] + 36'd1) : rm[35:0];
            end
        end
    endtask

    task automatic run_div(input string req, input bit dbl, input logic [35:0] hi,
                           input logic [35:0] lo, input logic [35:0] dsor, input bit glitch);
        logic [35:0] eq, er, pq, pr;
        bit eovf;
        int elat, n;
        model(dbl, hi, lo, dsor, eq, er, eovf, elat);
        @(negedge clk);
        pq = quot_o; pr = rem_o;
        dbl_i = dbl; dend_hi_i = hi; dend_lo_i = lo; dsor_i = dsor; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (n < 200) begin
            @(negedge clk);
            n++;
            if (glitch && n == 5) begin
                dend_lo_i = 36'd1; dsor_i = 36'd1; start_i = 1'b1;
            end
            if (glitch && n == 6) start_i = 1'b0;
            if (done_o) break;
        end
        if (eovf) begin eq = pq; er = pr; end
        chk({req, " latency"}, 72'(n), 72'(elat));
        chk({req, " ovf"}, 72'(ovf_o), 72'(eovf));
        chk({req, " quotient"}, 72'(quot_o), 72'(eq));
        chk({req, " remainder"}, 72'(rem_o), 72'(er));
        @(negedge clk);
        chk({req, " R9 done pulse"}, 72'(done_o), 72'd0);
        chk({req, " R9 quotient held"}, 72'(quot_o), 72'(eq));
    endtask

    task automatic run72(input string req, input logic [71:0] v, input logic [35:0] dsor);
        run_div(req, 1'b1, v[71:36], v[35:0], dsor, 1'b0);
    endtask

    task automatic t_reset;
        chk("R1 done", 72'(done_o), 72'd0);
        chk("R1 ovf", 72'(ovf_o), 72'd0);
        chk("R1 quotient", 72'(quot_o), 72'd0);
        chk("R1 remainder", 72'(rem_o), 72'd0);
    endtask

    task automatic t_single_signs;
        run_div("R2 +100/+7", 1'b0, 36'd0, 36'd100, 36'd7, 1'b0);
        run_div("R2 -100/+7", 1'b0, 36'd0, -36'd100, 36'd7, 1'b0);
        run_div("R2 +100/-7", 1'b0, 36'd0, 36'd100, -36'd7, 1'b0);
        run_div("R2 -100/-7", 1'b0, 36'd0, -36'd100, -36'd7, 1'b0);
        run_div("R2 hi ignored", 1'b0, 36'hF_FFFF_FFFF, 36'h3_0000_1234, 36'h123, 1'b0);
        run_div("R2 long neg", 1'b0, 36'h5_5555_5555, -36'h3_0000_1234, -36'd5, 1'b0);
    endtask

    task automatic t_double;
        run_div("R3 pos", 1'b1, 36'h0_0000_0012, 36'h3_4567_89AB, 36'h0_0100_0000, 1'b0);
        run72("R3 neg dividend", -((72'd18 << 36) + 72'h3_4567_89AB), 36'h0_0100_0003);
        run72("R3 neg divisor", (72'd5 << 40) + 72'd77, -36'h0_0000_4321);
        run72("R3 small dividend long path R4", 72'd100, 36'd7);
    endtask

    task automatic t_latency;
        run_div("R4 short edge below", 1'b0, 36'd0, 36'd262143, 36'd3, 1'b0);
        run_div("R4 just above short", 1'b0, 36'd0, 36'd262144, 36'd3, 1'b0);
        run_div("R4 neg short", 1'b0, 36'd0, -36'd262143, 36'd1, 1'b0);
    endtask

    task automatic t_most_neg;
        run_div("R5 minword/3", 1'b0, 36'd0, 36'h8_0000_0000, 36'd3, 1'b0);
        run_div("R5 minword/-3", 1'b0, 36'd0, 36'h8_0000_0000, -36'd3, 1'b0);
    endtask

    task automatic t_overflow;
        run_div("R6 minword/-1", 1'b0, 36'd0, 36'h8_0000_0000, -36'd1, 1'b0);
        run72("R6 dbl big", 72'd1 << 36, 36'd3);
        run72("R6 +2^35 exact", 72'd7 << 35, 36'd7);
        run72("R6 one past min", (72'd7 << 35) + 72'd7, -36'd7);
    endtask

    task automatic t_zero;
        run_div("R7 single zero", 1'b0, 36'd0, 36'd55, 36'd0, 1'b0);
        run_div("R7 double zero", 1'b1, 36'd0, 36'd0, 36'd0, 1'b0);
    endtask

    task automatic t_minq;
        run_div("R8 minword/1", 1'b0, 36'd0, 36'h8_0000_0000, 36'd1, 1'b0);
        run72("R8 neg dividend", -((72'd7 << 35) + 72'd3), 36'd7);
        run72("R8 neg divisor", (72'd7 << 35) + 72'd6, -36'd7);
    endtask

    task automatic t_busy;
        run_div("R10 start ignored", 1'b0, 36'd0, 36'h2_0000_0001, 36'd9, 1'b1);
    endtask

    initial begin
        #500000;
        if (!ended) begin
            ended = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_signs();
        t_double();
        t_latency();
        t_most_neg();
        t_overflow();
        t_zero();
        t_minq();
        t_busy();
        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule